// File: doc/BRIEF.md
# Infrared Pulse-Train Run-Length Receiver

This block sits behind an infrared demodulator and turns its single-bit output into a compact stream of bytes for software. The input is synchronised and then sampled once per sample period. That period is a parameterised fraction of the core clock, and a configuration bit chooses between a short divider and a long one. The sampled level can be inverted, so that a demodulator driving low during a burst still yields "pulse = 1". A hysteresis filter then keeps short excursions from splitting a run.

Each run of constant filtered level becomes one or more bytes. Bit 7 of each byte carries the level and bits 6:0 carry the run length in samples. The bytes go into a receive FIFO whose depth is selectable. A space that lasts long enough closes the packet, and the receiver then waits for the next pulse. Three sticky flags (overflow, packet end, data available) feed one interrupt line through per-flag enables. The FIFO is read through a valid/ready port.

Top module: `irRleRx`

## Requirements
- R1: One sample is taken every DIV_SLOW core clocks when cfgSlowSample is 1, and every DIV_FAST clocks when it is 0. The defaults are 128 and 64. A level held for k sample periods counts as k samples.
- R2: Every FIFO byte holds the level in bit 7 (1 = pulse, 0 = space) and a run length of 1 to 127 samples in bits 6:0. After reset or an idle period, the first byte written describes a pulse, and spaces before it are not recorded.
- R3: When cfgInvert is 1, the sampled pin level is inverted before filtering. An idle-high pin then reads as space.
- R4: The filtered level changes only after cfgFilter consecutive samples at the new level. A value of 0 or 1 means the change takes effect at once. A shorter excursion counts as part of the surrounding run.
- R5: A run longer than 127 samples is written as successive bytes of the same level: full bytes of 127, then the remainder.
- R6: Let T = (cfgIdle+1)*128. When a space inside a packet reaches T samples, its first T-1 samples are written (split as in R5). The packet-end flag, statFlags bit 1, is then set, and nothing more is written until the next pulse.
- R7: Samples are taken only while both cfgGlobalEn and cfgRxEn are 1. Otherwise no byte is written, and the sampler, filter and run state are cleared.
- R8: The FIFO holds 64 entries when cfgDeepFifo is 1 and 16 when it is 0. fifoCount gives the number of stored bytes. Bytes come out in write order, and one byte is removed on each cycle in which rdValid and rdReady are both 1.
- R9: A byte produced while the FIFO is full is dropped, and the stored contents stay unchanged. The overflow flag, statFlags bit 0, is set and stays set until it is cleared.
- R10: The data-available flag, statFlags bit 2, is set whenever fifoCount is greater than cfgAvailLevel.
- R11: Flags are sticky. A 1 in clrFlags clears the matching flag, but a set condition in the same cycle takes priority. irq is the OR of the flags enabled by cfgIrqEn, using the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irIn | input | 1 | Demodulator output, asynchronous |
| cfgGlobalEn | input | 1 | Block enable |
| cfgRxEn | input | 1 | Receive enable |
| cfgSlowSample | input | 1 | 1 selects the long sample divider |
| cfgInvert | input | 1 | Invert the sampled level |
| cfgFilter | input | 6 | Minimum samples before a level change is accepted |
| cfgIdle | input | 8 | Idle threshold field N, end after (N+1)*128 space samples |
| cfgDeepFifo | input | 1 | 1 selects the 64-entry depth, 0 the 16-entry depth |
| cfgAvailLevel | input | 6 | Data-available threshold |
| cfgIrqEn | input | 3 | Interrupt enables: bit 0 overflow, 1 packet end, 2 available |
| clrFlags | input | 3 | Write-one-to-clear pulses for statFlags |
| rdData | output | 8 | FIFO head byte |
| rdValid | output | 1 | FIFO not empty |
| rdReady | input | 1 | Pop the head byte |
| fifoCount | output | 7 | Stored byte count |
| statFlags | output | 3 | Sticky flags: bit 0 overflow, 1 packet end, 2 available |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- every written byte has a non-zero length;
- a packet end always comes with a space byte;
- the fill never exceeds the selected depth and never rises while the receiver is disabled;
- overflow and data-available flags rise the cycle after their cause, and the overflow flag holds until it is cleared.

Only the bench scenarios can show that the byte stream is right for a given waveform, which means checking:
- the run lengths under each divider;
- polarity inversion;
- absorption of glitches by the filter;
- splitting of long runs;
- the truncated closing space at the idle threshold;
- which bytes survive an overflow.

// File: rtl/irRlePkg.sv
package irRlePkg;
  localparam int RUN_W = 7;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam int FLAG_OVF   = 0;
  localparam int FLAG_PKT   = 1;
  localparam int FLAG_AVAIL = 2;
  localparam int FLAG_N     = 3;

  typedef struct packed {
    logic             push;
    logic [RUN_W:0]   data;
    logic             pktEnd;
  } runStb_t;
endpackage

// File: rtl/irRleSampler.sv
module irRleSampler
  import irRlePkg::*;
#(
  parameter int DIV_FAST = 64,
  parameter int DIV_SLOW = 128,
  parameter int FILT_W   = 6,
  parameter int IDLE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              running,
  input  logic              slowSample,
  input  logic              invert,
  input  logic [FILT_W-1:0] filterLen,
  input  logic [IDLE_W-1:0] idleLen,
  output runStb_t           stb
);
  localparam int DIV_W = $clog2(DIV_SLOW);
  localparam int IDLE_CNT_W = IDLE_W + 8;
  localparam logic [DIV_W-1:0] LIM_FAST = DIV_W'(DIV_FAST - 1);
  localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(DIV_SLOW - 1);

  logic syncA, syncB;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic tick;
  logic sampleLvl;
  logic filtLvl;
  logic [FILT_W-1:0] pendCnt;
  logic [FILT_W:0] pendNext;
  logic accept, newLvl;
  logic inIdle, runLvl;
  logic [RUN_W-1:0] runLen;
  logic [IDLE_CNT_W-1:0] idleCnt, idleLimit;
  logic idleHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= irIn;
      syncB <= syncA;
    end
  end

  assign divLim = slowSample ? LIM_SLOW : LIM_FAST;
  assign tick   = running && (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (!running || tick) divCnt <= '0;
    else                       divCnt <= divCnt + DIV_W'(1);
  end

  assign sampleLvl = syncB ^ invert;
  assign pendNext  = {1'b0, pendCnt} + (FILT_W+1)'(1);
  assign accept    = (sampleLvl != filtLvl) && (pendNext >= {1'b0, filterLen});
  assign newLvl    = accept ? sampleLvl : filtLvl;

  assign idleLimit = (IDLE_CNT_W'(idleLen) + IDLE_CNT_W'(1)) << 7;
  assign idleHit   = !newLvl && !inIdle && !runLvl &&
                     ((idleCnt + IDLE_CNT_W'(1)) == idleLimit);

  always_comb begin
    stb = '0;
    if (tick && !inIdle) begin
      if (newLvl != runLvl) begin
        stb.push = 1'b1;
        stb.data = {runLvl, runLen};
      end else if (idleHit) begin
        stb.push   = 1'b1;
        stb.data   = {1'b0, runLen};
        stb.pktEnd = 1'b1;
      end else if (runLen == RUN_MAX) begin
        stb.push = 1'b1;
        stb.data = {runLvl, RUN_MAX};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLvl <= 1'b0;
      pendCnt <= '0;
      inIdle  <= 1'b1;
      runLvl  <= 1'b0;
      runLen  <= '0;
      idleCnt <= '0;
    end else if (!running) begin
      filtLvl <= 1'b0;
      pendCnt <= '0;
      inIdle  <= 1'b1;
      runLvl  <= 1'b0;
      runLen  <= '0;
      idleCnt <= '0;
    end else if (tick) begin
      filtLvl <= newLvl;
      pendCnt <= (sampleLvl != filtLvl && !accept) ? pendNext[FILT_W-1:0] : '0;
      if (inIdle) begin
        if (newLvl) begin
          inIdle  <= 1'b0;
          runLvl  <= 1'b1;
          runLen  <= RUN_W'(1);
          idleCnt <= '0;
        end
      end else if (newLvl != runLvl) begin
        runLvl  <= newLvl;
        runLen  <= RUN_W'(1);
        idleCnt <= newLvl ? '0 : IDLE_CNT_W'(1);
      end else if (idleHit) begin
        inIdle  <= 1'b1;
        runLen  <= '0;
        idleCnt <= '0;
      end else begin
        runLen  <= (runLen == RUN_MAX) ? RUN_W'(1) : runLen + RUN_W'(1);
        idleCnt <= newLvl ? '0 : idleCnt + IDLE_CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/irRleFifo.sv
module irRleFifo
  import irRlePkg::*;
#(
  parameter int DEPTH_SMALL = 16,
  parameter int DEPTH_LARGE = 64,
  parameter int LVL_W       = 6,
  localparam int PTR_W      = $clog2(DEPTH_LARGE),
  localparam int CNT_W      = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  runStb_t           stb,
  input  logic              deep,
  input  logic [LVL_W-1:0]  availLevel,
  input  logic [FLAG_N-1:0] irqEn,
  input  logic [FLAG_N-1:0] clrFlags,
  input  logic              rdReady,
  output logic [RUN_W:0]    rdData,
  output logic              rdValid,
  output logic [CNT_W-1:0]  fifoCount,
  output logic [FLAG_N-1:0] statFlags,
  output logic              irq
);
  logic [RUN_W:0] mem [DEPTH_LARGE];
  logic [PTR_W-1:0] wrPtr, rdPtr, ptrMask;
  logic [CNT_W-1:0] depth;
  logic full, doPush, doPop;
  logic [FLAG_N-1:0] setVec;

  assign depth   = deep ? CNT_W'(DEPTH_LARGE) : CNT_W'(DEPTH_SMALL);
  assign ptrMask = deep ? PTR_W'(DEPTH_LARGE - 1) : PTR_W'(DEPTH_SMALL - 1);
  assign full    = fifoCount >= depth;
  assign rdValid = fifoCount != '0;
  assign doPush  = stb.push && !full;
  assign doPop   = rdReady && rdValid;
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= stb.data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr + PTR_W'(1)) & ptrMask;
      if (doPop)  rdPtr <= (rdPtr + PTR_W'(1)) & ptrMask;
      case ({doPush, doPop})
        2'b10:   fifoCount <= fifoCount + CNT_W'(1);
        2'b01:   fifoCount <= fifoCount - CNT_W'(1);
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  always_comb begin
    setVec             = '0;
    setVec[FLAG_OVF]   = stb.push && full;
    setVec[FLAG_PKT]   = stb.pktEnd;
    setVec[FLAG_AVAIL] = fifoCount > CNT_W'(availLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statFlags <= '0;
    else       statFlags <= (statFlags & ~clrFlags) | setVec;
  end

  assign irq = |(statFlags & irqEn);
endmodule

// File: rtl/irRleRx.sv
module irRleRx
  import irRlePkg::*;
#(
  parameter int DIV_FAST    = 64,
  parameter int DIV_SLOW    = 128,
  parameter int DEPTH_SMALL = 16,
  parameter int DEPTH_LARGE = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       irIn,
  input  logic       cfgGlobalEn,
  input  logic       cfgRxEn,
  input  logic       cfgSlowSample,
  input  logic       cfgInvert,
  input  logic [5:0] cfgFilter,
  input  logic [7:0] cfgIdle,
  input  logic       cfgDeepFifo,
  input  logic [5:0] cfgAvailLevel,
  input  logic [2:0] cfgIrqEn,
  input  logic [2:0] clrFlags,
  output logic [7:0] rdData,
  output logic       rdValid,
  input  logic       rdReady,
  output logic [6:0] fifoCount,
  output logic [2:0] statFlags,
  output logic       irq
);
  runStb_t runStb;
  logic running;

  assign running = cfgGlobalEn && cfgRxEn;

  irRleSampler #(
    .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .FILT_W(6), .IDLE_W(8)
  ) sampler_i (
    .clk(clk), .rstN(rstN), .irIn(irIn), .running(running),
    .slowSample(cfgSlowSample), .invert(cfgInvert),
    .filterLen(cfgFilter), .idleLen(cfgIdle), .stb(runStb)
  );

  irRleFifo #(
    .DEPTH_SMALL(DEPTH_SMALL), .DEPTH_LARGE(DEPTH_LARGE), .LVL_W(6)
  ) fifo_i (
    .clk(clk), .rstN(rstN), .stb(runStb), .deep(cfgDeepFifo),
    .availLevel(cfgAvailLevel), .irqEn(cfgIrqEn), .clrFlags(clrFlags),
    .rdReady(rdReady), .rdData(rdData), .rdValid(rdValid),
    .fifoCount(fifoCount), .statFlags(statFlags), .irq(irq)
  );
endmodule

// File: rtl/irRleChk.sv
module irRleChk #(
  parameter int DEPTH_SMALL = 16,
  parameter int DEPTH_LARGE = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       cfgGlobalEn,
  input logic       cfgRxEn,
  input logic       cfgDeepFifo,
  input logic [5:0] cfgAvailLevel,
  input logic       clrOvf,
  input logic       clrPkt,
  input logic [6:0] fifoCount,
  input logic [2:0] statFlags,
  input logic       stbPush,
  input logic [7:0] stbData,
  input logic       stbPktEnd
);
  logic [6:0] depth;
  assign depth = cfgDeepFifo ? 7'(DEPTH_LARGE) : 7'(DEPTH_SMALL);

  // R2
  nonzero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbPush |-> (stbData[6:0] != 7'd0));

  // R6
  pkt_end_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbPktEnd |-> (stbPush && !stbData[7]));

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= depth);

  // R7
  idle_no_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgGlobalEn && cfgRxEn) |=> fifoCount <= $past(fifoCount));

  // R9
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbPush && fifoCount >= depth) |=> statFlags[0]);

  // R9
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statFlags[0] && !clrOvf) |=> statFlags[0]);

  // R10
  avail_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount > {1'b0, cfgAvailLevel}) |=> statFlags[2]);

  // R11
  pkt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrPkt && !stbPktEnd) |=> !statFlags[1]);
endmodule

bind irRleRx irRleChk #(.DEPTH_SMALL(DEPTH_SMALL), .DEPTH_LARGE(DEPTH_LARGE)) chk_i (
  .clk(clk), .rstN(rstN), .cfgGlobalEn(cfgGlobalEn), .cfgRxEn(cfgRxEn),
  .cfgDeepFifo(cfgDeepFifo), .cfgAvailLevel(cfgAvailLevel),
  .clrOvf(clrFlags[0]), .clrPkt(clrFlags[1]), .fifoCount(fifoCount),
  .statFlags(statFlags), .stbPush(runStb.push), .stbData(runStb.data),
  .stbPktEnd(runStb.pktEnd)
);

// File: tb/irRleRx_tb_top.sv
module irRleRx_tb_top;
  localparam int DF = 4;
  localparam int DS = 8;
  localparam int DSM = 16;
  localparam int DLG = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, irIn, cfgGlobalEn, cfgRxEn, cfgSlowSample, cfgInvert, cfgDeepFifo, rdReady;
  logic [5:0] cfgFilter, cfgAvailLevel;
  logic [7:0] cfgIdle;
  logic [2:0] cfgIrqEn, clrFlags;
  logic [7:0] rdData;
  logic rdValid, irq;
  logic [6:0] fifoCount;
  logic [2:0] statFlags;

  int testCount = 0;
  int failCount = 0;
  logic seq [0:4095];
  logic filt [0:4095];
  int seqLen;
  logic [7:0] expB [0:255];
  int expN, expPkt;

  irRleRx #(.DIV_FAST(DF), .DIV_SLOW(DS), .DEPTH_SMALL(DSM), .DEPTH_LARGE(DLG)) dut_i (
    .clk(clk), .rstN(rstN), .irIn(irIn), .cfgGlobalEn(cfgGlobalEn), .cfgRxEn(cfgRxEn),
    .cfgSlowSample(cfgSlowSample), .cfgInvert(cfgInvert), .cfgFilter(cfgFilter),
    .cfgIdle(cfgIdle), .cfgDeepFifo(cfgDeepFifo), .cfgAvailLevel(cfgAvailLevel),
    .cfgIrqEn(cfgIrqEn), .clrFlags(clrFlags), .rdData(rdData), .rdValid(rdValid),
    .rdReady(rdReady), .fifoCount(fifoCount), .statFlags(statFlags), .irq(irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void emitSplit(logic lvl, int len);
    while (len > 127) begin
      if (expN < 256) expB[expN] = {lvl, 7'd127};
      expN++;
      len -= 127;
    end
    if (expN < 256) expB[expN] = {lvl, 7'(len)};
    expN++;
  endfunction

  function automatic void buildExpected(int fLen, int idleN);
    int thr;
    logic f;
    int p;
    int t;
    bit idle;
    thr = (idleN + 1) * 128;
    f = 1'b0; p = 0; expN = 0; expPkt = 0;
    for (int i = 0; i < seqLen; i++) begin
      if (seq[i] != f) begin
        if (p + 1 >= fLen) begin f = seq[i]; p = 0; end
        else p++;
      end else p = 0;
      filt[i] = f;
    end
    t = 0; idle = 1'b1;
    while (t < seqLen) begin
      int e;
      int len;
      e = t;
      while (e < seqLen && filt[e] == filt[t]) e++;
      len = e - t;
      if (filt[t]) begin
        emitSplit(1'b1, len);
        idle = 1'b0;
      end else if (!idle) begin
        if (len >= thr) begin
          emitSplit(1'b0, thr - 1);
          expPkt++;
          idle = 1'b1;
        end else if (e < seqLen) emitSplit(1'b0, len);
      end
      t = e;
    end
  endfunction

  task automatic addRun(logic lvl, int n);
    for (int i = 0; i < n; i++) begin
      if (seqLen < 4096) begin seq[seqLen] = lvl; seqLen++; end
    end
  endtask

  task automatic driveSeq(int div, logic inv, logic ge, logic rx);
    @(negedge clk);
    cfgGlobalEn = ge;
    cfgRxEn = rx;
    for (int j = 0; j < seqLen; j++) begin
      irIn = seq[j] ^ inv;
      repeat (div) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cfgGlobalEn = 1'b0;
    cfgRxEn = 1'b0;
    irIn = inv;
    @(negedge clk);
  endtask

  task automatic drain(string req, int n);
    for (int i = 0; i < n; i++) begin
      check(req, "rdValid", 32'(rdValid), 32'd1);
      check(req, $sformatf("byte %0d", i), 32'(rdData), 32'(expB[i]));
      rdReady = 1'b1;
      @(negedge clk);
      rdReady = 1'b0;
    end
    check(req, "empty after drain", 32'(rdValid), 32'd0);
  endtask

  task automatic clearAll(string req);
    clrFlags = 3'b111;
    @(negedge clk);
    clrFlags = 3'b000;
    @(negedge clk);
    check(req, "flags after clear", 32'(statFlags), 32'd0);
  endtask

  task automatic runCase(string req, int fLen, int idleN, logic inv, logic slow,
                         logic deep, int level);
    int depth;
    int keep;
    logic [2:0] expFlags;
    cfgFilter = 6'(fLen);
    cfgIdle = 8'(idleN);
    cfgInvert = inv;
    cfgSlowSample = slow;
    cfgDeepFifo = deep;
    cfgAvailLevel = 6'(level);
    irIn = inv;
    buildExpected(fLen, idleN);
    driveSeq(slow ? DS : DF, inv, 1'b1, 1'b1);
    depth = deep ? DLG : DSM;
    keep = (expN > depth) ? depth : expN;
    check(req, "fifoCount", 32'(fifoCount), 32'(keep));
    expFlags[0] = expN > depth;
    expFlags[1] = expPkt > 0;
    expFlags[2] = keep > level;
    check(req, "flags", 32'(statFlags), 32'(expFlags));
    drain(req, keep);
    clearAll(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; irIn = 1'b0; cfgGlobalEn = 1'b0; cfgRxEn = 1'b0;
    cfgSlowSample = 1'b1; cfgInvert = 1'b0; cfgFilter = 6'd0; cfgIdle = 8'd0;
    cfgDeepFifo = 1'b1; cfgAvailLevel = 6'd63; cfgIrqEn = 3'b000;
    clrFlags = 3'b000; rdReady = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state (R8, R11)
    check("R8", "reset count", 32'(fifoCount), 32'd0);
    check("R8", "reset rdValid", 32'(rdValid), 32'd0);
    check("R11", "reset flags", 32'(statFlags), 32'd0);
    check("R11", "reset irq", 32'(irq), 32'd0);

    // R2: plain pulses and spaces, leading spaces dropped; also R10/R11 irq
    seqLen = 0;
    addRun(0, 20); addRun(1, 9); addRun(0, 4); addRun(1, 3); addRun(0, 17);
    addRun(1, 1); addRun(0, 2); addRun(1, 40); addRun(0, 6); addRun(1, 5); addRun(0, 140);
    cfgFilter = 6'd0; cfgIdle = 8'd0; cfgInvert = 1'b0; cfgSlowSample = 1'b1;
    cfgDeepFifo = 1'b1; cfgAvailLevel = 6'd7; cfgIrqEn = 3'b100;
    buildExpected(0, 0);
    driveSeq(DS, 1'b0, 1'b1, 1'b1);
    check("R2", "count", 32'(fifoCount), 32'(expN));
    check("R10", "avail flag", 32'(statFlags[2]), 32'd1);
    check("R11", "irq enabled", 32'(irq), 32'd1);
    cfgIrqEn = 3'b001;
    @(negedge clk);
    check("R11", "irq masked", 32'(irq), 32'd0);
    check("R6", "pkt flag", 32'(statFlags[1]), 32'd1);
    cfgIrqEn = 3'b000;
    drain("R2", expN);
    clearAll("R11");

    // R5 and R6: long pulse split, closing space truncated at T-1 with N=1
    seqLen = 0;
    addRun(0, 3); addRun(1, 300); addRun(0, 300);
    runCase("R5", 0, 1, 1'b0, 1'b1, 1'b1, 63);
    check("R5", "model bytes", 32'(expN), 32'd6);

    // R6: mid-stream packet end, then a second packet
    seqLen = 0;
    addRun(0, 3); addRun(1, 10); addRun(0, 200); addRun(1, 7); addRun(0, 130);
    runCase("R6", 0, 0, 1'b0, 1'b1, 1'b1, 63);

    // R3: inverted pin
    seqLen = 0;
    addRun(0, 5); addRun(1, 12); addRun(0, 8); addRun(1, 30); addRun(0, 140);
    runCase("R3", 0, 0, 1'b1, 1'b1, 1'b1, 63);

    // R4: glitches shorter than the filter are absorbed
    seqLen = 0;
    addRun(0, 5); addRun(1, 2); addRun(0, 6); addRun(1, 10); addRun(0, 2);
    addRun(1, 10); addRun(0, 1); addRun(1, 4); addRun(0, 140);
    runCase("R4", 3, 0, 1'b0, 1'b1, 1'b1, 63);

    // R1: fast divider
    seqLen = 0;
    addRun(0, 4); addRun(1, 15); addRun(0, 9); addRun(1, 130); addRun(0, 140);
    runCase("R1", 0, 0, 1'b0, 1'b0, 1'b1, 63);

    // R7: disabled receive or disabled block records nothing
    seqLen = 0;
    addRun(0, 3); addRun(1, 20); addRun(0, 20); addRun(1, 20); addRun(0, 5);
    driveSeq(DS, 1'b0, 1'b1, 1'b0);
    check("R7", "rx disabled count", 32'(fifoCount), 32'd0);
    driveSeq(DS, 1'b0, 1'b0, 1'b1);
    check("R7", "global disabled count", 32'(fifoCount), 32'd0);
    check("R7", "disabled flags", 32'(statFlags), 32'd0);

    // R9: overflow on the 16-entry depth keeps the oldest bytes
    seqLen = 0;
    addRun(0, 3);
    for (int k = 0; k < 12; k++) begin addRun(1, 5); addRun(0, 5); end
    addRun(0, 140);
    runCase("R9", 0, 0, 1'b0, 1'b1, 1'b0, 63);

    // R8: random waveforms, both depths and dividers
    for (int r = 0; r < 4; r++) begin
      int n;
      seqLen = 0;
      addRun(0, 3);
      n = $urandom_range(3, 7);
      for (int k = 0; k < n; k++) begin
        addRun(1, $urandom_range(1, 150));
        addRun(0, $urandom_range(1, 140));
      end
      addRun(0, 140);
      runCase("R8", $urandom_range(0, 3), 0, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'b1, $urandom_range(4, 40));
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule